// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which of sixteen prioritized event levels a processor core services next. Level 0 is the most urgent and level 15 the least. Level 0 serves emulation, 1 reset, 2 the non-maskable interrupt and 3 exceptions. Bit 4 is not an event: it is a global-disable flag kept in the pending register. Level 5 is hardware error, level 6 the core timer, and levels 7 to 15 are general purpose. The block keeps five 16-bit state words: a mask, a latch of requested events, a pending (in-service) set, a priority word and a vector-override word. Software reaches them over a simple 32-bit register bus with word addresses. Register reads are combinational, and only the low 16 bits carry data.

Requests reach the block in three ways. A direct request names one level, and the block decides at once whether to enter it. Latch-only request lines just record events. A return input leaves a level. After a mask write, a latch set, a direct request, a return or an entry, a background check runs in the next cycle. It looks for a latched and unmasked level that may pre-empt the current one. Each accepted event gives a one-cycle entry strobe. The strobe carries the level, a return-register select, a self-nesting tag for the return address, a flag that makes an exception return to the next instruction, and a flag that redirects the handler to the reset vector. A direct request for level 2 or 3 that may not be taken raises a double-fault pulse instead.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After reset the mask reads 0x001F, pending reads 0x0012, and latch, priority and override read 0. Entry and double-fault outputs are low, and the current level output reads 1.
- R2: A mask write (word address 0) loads bits 5..15 from write data bits 5..15, and bits 0..4 stay 1.
- R3: Writes to the pending register (word address 2) have no effect on it.
- R4: Writing 1 to a latch bit (word address 1) clears it, except bits 0 and 4, which writes never clear. Latch bit 4 is never set. A priority write (word address 3) keeps only write data bits 0..4.
- R5: A direct request for level 0 or 1 is always accepted, even while the global-disable bit (pending bit 4) is set.
- R6: A direct request for level 5 or above, made while pending bit 4 is set and the core is not at user level, only sets its latch bit and gives no entry.
- R7: A direct request for a level 5 or above whose mask bit is 0 only sets its latch bit. Setting the mask bit later lets the background check accept the level.
- R8: An accepted level sets its pending bit and clears its latch bit. One cycle after the request, it gives a one-cycle entry strobe with that level. A level of 5 or above also sets pending bit 4. The return select encodes 0 for emulation, 1 for NMI, 2 for exception and 3 for all others.
- R9: An event at the current level is accepted only when nesting is enabled, and its entry tag is then 1. An event of lower priority (higher number) than the current level is not accepted.
- R10: A direct request for level 2 or 3 while the current level is numerically at or below it gives a one-cycle double-fault pulse instead of an entry, and the latch bit stays set.
- R11: With pending bit 4 clear, the background check accepts the lowest-numbered latched and unmasked level that outranks the current level. The entry strobe comes one cycle after the triggering event has been registered.
- R12: A return clears the pending bit of its level unless the nested flag is given. A return from level 1 or from level 5 or above clears pending bit 4. The current level output is the lowest set pending bit other than bits 0 and 4, or 16 when there is none.
- R13: An accepted exception (level 3) flags a return to the next instruction when the exception cause is below 0x20, and a return to the faulting instruction otherwise.
- R14: The reset-vector flag of an entry is set only when the level is 7 to 15 and its override bit (word address 4) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lat_req | input | 16 | Per-level latch-only requests |
| raise_vld | input | 1 | Direct request valid |
| raise_lvl | input | 4 | Direct request level |
| exc_cause | input | 6 | Exception cause for a level 3 entry |
| nest_en | input | 1 | Self-nesting enable |
| ret_vld | input | 1 | Return from a level |
| ret_lvl | input | 4 | Level being returned from |
| ret_nested | input | 1 | Return address carried the nesting tag |
| ent_stb | output | 1 | One-cycle entry strobe |
| ent_lvl | output | 4 | Accepted level |
| ent_rsel | output | 2 | Return register select |
| ent_tag | output | 1 | Self-nesting tag for the return address |
| ent_next | output | 1 | Exception returns to next instruction |
| ent_rstvec | output | 1 | Use reset vector for handler |
| dbl_flt | output | 1 | Double-fault pulse |
| cur_lvl | output | 5 | Current level, 16 for user |

## Verification
The acceptance logic is driven by direct requests in four states: right after reset with the disable bit set, at user level, inside a general level with the disable bit cleared by a nested return, and inside the NMI level. This separates the blocking by the disable bit, by the mask, by priority and by the nesting setting. Latched events are then released by a return or by a mask write. This shows that the background path picks the lowest set level and fires exactly one cycle later. Exceptions are raised with causes on both sides of 0x20 and at a level where they must become a double fault. Override bits are set on levels 6 and 12 to show which range is honoured.

// File: rtl/nec_pkg.sv
package nec_pkg;
  localparam int NLVL = 16;
  localparam int LVLW = $clog2(NLVL);
  localparam int CURW = LVLW + 1;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int CAUSEW = 6;

  localparam logic [LVLW-1:0] LV_EMU = 4'd0;
  localparam logic [LVLW-1:0] LV_RST = 4'd1;
  localparam logic [LVLW-1:0] LV_NMI = 4'd2;
  localparam logic [LVLW-1:0] LV_EXC = 4'd3;
  localparam logic [LVLW-1:0] LV_GDIS = 4'd4;
  localparam logic [LVLW-1:0] LV_HWERR = 4'd5;

  localparam logic [NLVL-1:0] FIXED_BITS = 16'h001F;
  localparam logic [NLVL-1:0] CLR_ALLOW = 16'hFFEE;
  localparam logic [NLVL-1:0] OVR_ALLOW = 16'hFF80;
  localparam logic [NLVL-1:0] IGNORE_BITS = (NLVL'(1) << LV_EMU) | (NLVL'(1) << LV_GDIS);
  localparam logic [NLVL-1:0] PEND_RST = (NLVL'(1) << LV_RST) | (NLVL'(1) << LV_GDIS);
  localparam logic [CAUSEW-1:0] CAUSE_ERR = 6'h20;
  localparam logic [CURW-1:0] CUR_USER = CURW'(NLVL);

  localparam logic [AW-1:0] A_MASK = 3'd0;
  localparam logic [AW-1:0] A_LATCH = 3'd1;
  localparam logic [AW-1:0] A_PEND = 3'd2;
  localparam logic [AW-1:0] A_PRIO = 3'd3;
  localparam logic [AW-1:0] A_OVR = 3'd4;

  typedef enum logic [1:0] {RS_EMU = 2'd0, RS_NMI = 2'd1, RS_EXC = 2'd2, RS_INT = 2'd3} rsel_e;

  // Lowest set bit index, or CUR_USER when the vector is empty.
  function automatic logic [CURW-1:0] first_set(input logic [NLVL-1:0] v);
    logic [CURW-1:0] r;
    r = CUR_USER;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (v[i]) r = CURW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/nec_regs.sv
module nec_regs
  import nec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NLVL-1:0] lat_req,
  input  logic            raise_vld,
  input  logic [LVLW-1:0] raise_lvl,
  input  logic            acc_vld,
  input  logic [LVLW-1:0] acc_lvl,
  input  logic            ret_vld,
  input  logic [LVLW-1:0] ret_lvl,
  input  logic            ret_nested,
  output logic [NLVL-1:0] imask_q,
  output logic [NLVL-1:0] ilat_q,
  output logic [NLVL-1:0] ipend_q,
  output logic [NLVL-1:0] ovr_q
);
  logic [NLVL-1:0] prio_q, wd;
  logic [NLVL-1:0] imask_n, ilat_n, ipend_n, prio_n, ovr_n;
  logic [NLVL-1:0] set_bits, clr_bits, acc_bit, ret_bit;
  logic wr_mask, wr_lat, wr_prio, wr_ovr, ret_gclr, acc_gset;
  logic en_mask, en_lat, en_pend, en_prio, en_ovr;

  assign wd = reg_wdata[NLVL-1:0];

  always_comb begin
    wr_mask = reg_we && (reg_addr == A_MASK);
    wr_lat  = reg_we && (reg_addr == A_LATCH);
    wr_prio = reg_we && (reg_addr == A_PRIO);
    wr_ovr  = reg_we && (reg_addr == A_OVR);

    set_bits = lat_req;
    if (raise_vld) set_bits[raise_lvl] = 1'b1;
    set_bits[LV_GDIS] = 1'b0;
    clr_bits = wr_lat ? (wd & CLR_ALLOW) : '0;
    acc_bit = '0;
    if (acc_vld) acc_bit[acc_lvl] = 1'b1;
    ret_bit = '0;
    if (ret_vld && !ret_nested && (ret_lvl != LV_GDIS)) ret_bit[ret_lvl] = 1'b1;
    ret_gclr = ret_vld && ((ret_lvl == LV_RST) || (ret_lvl >= LV_HWERR));
    acc_gset = acc_vld && (acc_lvl >= LV_HWERR);

    imask_n = (wd & ~FIXED_BITS) | FIXED_BITS;
    prio_n  = wd & FIXED_BITS;
    ovr_n   = wd;
    ilat_n  = ((ilat_q & ~clr_bits) | set_bits) & ~acc_bit;
    ipend_n = (ipend_q & ~ret_bit) | acc_bit;
    if (ret_gclr) ipend_n[LV_GDIS] = 1'b0;
    if (acc_gset) ipend_n[LV_GDIS] = 1'b1;

    en_mask = wr_mask;
    en_prio = wr_prio;
    en_ovr  = wr_ovr;
    en_lat  = wr_lat || (|set_bits) || acc_vld;
    en_pend = acc_vld || ret_vld;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK:  reg_rdata[NLVL-1:0] = imask_q;
      A_LATCH: reg_rdata[NLVL-1:0] = ilat_q;
      A_PEND:  reg_rdata[NLVL-1:0] = ipend_q;
      A_PRIO:  reg_rdata[NLVL-1:0] = prio_q;
      A_OVR:   reg_rdata[NLVL-1:0] = ovr_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= FIXED_BITS;
      ilat_q  <= '0;
      ipend_q <= PEND_RST;
      prio_q  <= '0;
      ovr_q   <= '0;
    end else begin
      if (en_mask) imask_q <= imask_n;
      if (en_lat)  ilat_q  <= ilat_n;
      if (en_pend) ipend_q <= ipend_n;
      if (en_prio) prio_q  <= prio_n;
      if (en_ovr)  ovr_q   <= ovr_n;
    end
  end

  assert_mask_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> imask_q == (($past(wd) & ~FIXED_BITS) | FIXED_BITS));
  assert_pend_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PEND && !acc_vld && !ret_vld) |=> $stable(ipend_q));
  assert_latch_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lat && ilat_q[LV_EMU] && !(acc_vld && acc_lvl == LV_EMU)) |=> ilat_q[LV_EMU]);
endmodule

// File: rtl/nec_arb.sv
module nec_arb
  import nec_pkg::*;
(
  input  logic [NLVL-1:0] ipend,
  input  logic [NLVL-1:0] ilat,
  input  logic [NLVL-1:0] imask,
  input  logic            nest_en,
  input  logic            chk,
  input  logic            raise_vld,
  input  logic [LVLW-1:0] raise_lvl,
  output logic            acc_vld,
  output logic [LVLW-1:0] acc_lvl,
  output logic            dbl,
  output logic [CURW-1:0] cur
);
  logic [CURW-1:0] rl, bg;
  logic gdis, user;

  always_comb begin
    cur  = first_set(ipend & ~IGNORE_BITS);
    gdis = ipend[LV_GDIS];
    user = (cur == CUR_USER);
    rl   = {1'b0, raise_lvl};
    bg   = first_set(ilat & imask);
    acc_vld = 1'b0;
    acc_lvl = raise_lvl;
    dbl     = 1'b0;
    if (raise_vld) begin
      if (raise_lvl <= LV_RST) begin
        acc_vld = 1'b1;
      end else if (raise_lvl <= LV_EXC) begin
        if (cur <= rl) dbl = 1'b1;
        else acc_vld = 1'b1;
      end else if ((raise_lvl != LV_GDIS) && !(gdis && !user) && imask[raise_lvl] &&
                   ((rl < cur) || (nest_en && (rl == cur)))) begin
        acc_vld = 1'b1;
      end
    end else if (chk && !gdis && (bg != CUR_USER) &&
                 ((bg < cur) || (nest_en && (bg == cur)))) begin
      acc_vld = 1'b1;
      acc_lvl = bg[LVLW-1:0];
    end
  end
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
  import nec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NLVL-1:0]   lat_req,
  input  logic              raise_vld,
  input  logic [LVLW-1:0]   raise_lvl,
  input  logic [CAUSEW-1:0] exc_cause,
  input  logic              nest_en,
  input  logic              ret_vld,
  input  logic [LVLW-1:0]   ret_lvl,
  input  logic              ret_nested,
  output logic              ent_stb,
  output logic [LVLW-1:0]   ent_lvl,
  output logic [1:0]        ent_rsel,
  output logic              ent_tag,
  output logic              ent_next,
  output logic              ent_rstvec,
  output logic              dbl_flt,
  output logic [CURW-1:0]   cur_lvl
);
  logic [1:0] rsync_q;
  logic rstn_i;
  logic [NLVL-1:0] imask_q, ilat_q, ipend_q, ovr_q;
  logic acc_vld, dbl, chk_q, chk_n;
  logic [LVLW-1:0] acc_lvl;
  logic [CURW-1:0] cur;
  rsel_e rsel_n, rsel_q;
  logic tag_n, next_n, rstvec_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rstn_i = rsync_q[1];

  nec_regs u_regs (
    .clk(clk), .rst_n(rstn_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lat_req(lat_req), .raise_vld(raise_vld), .raise_lvl(raise_lvl),
    .acc_vld(acc_vld), .acc_lvl(acc_lvl),
    .ret_vld(ret_vld), .ret_lvl(ret_lvl), .ret_nested(ret_nested),
    .imask_q(imask_q), .ilat_q(ilat_q), .ipend_q(ipend_q), .ovr_q(ovr_q)
  );

  nec_arb u_arb (
    .ipend(ipend_q), .ilat(ilat_q), .imask(imask_q), .nest_en(nest_en), .chk(chk_q),
    .raise_vld(raise_vld), .raise_lvl(raise_lvl),
    .acc_vld(acc_vld), .acc_lvl(acc_lvl), .dbl(dbl), .cur(cur)
  );

  always_comb begin
    chk_n = (reg_we && (reg_addr == A_MASK)) || (|lat_req) || raise_vld || ret_vld || acc_vld;
    case (acc_lvl)
      LV_EMU:  rsel_n = RS_EMU;
      LV_NMI:  rsel_n = RS_NMI;
      LV_EXC:  rsel_n = RS_EXC;
      default: rsel_n = RS_INT;
    endcase
    tag_n    = (acc_lvl >= LV_HWERR) && ({1'b0, acc_lvl} == cur);
    next_n   = (acc_lvl == LV_EXC) && (exc_cause < CAUSE_ERR);
    rstvec_n = ovr_q[acc_lvl] & OVR_ALLOW[acc_lvl];
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      ent_stb    <= 1'b0;
      ent_lvl    <= '0;
      rsel_q     <= RS_EMU;
      ent_tag    <= 1'b0;
      ent_next   <= 1'b0;
      ent_rstvec <= 1'b0;
      dbl_flt    <= 1'b0;
      chk_q      <= 1'b0;
    end else begin
      ent_stb <= acc_vld;
      dbl_flt <= dbl;
      chk_q   <= chk_n;
      if (acc_vld) begin
        ent_lvl    <= acc_lvl;
        rsel_q     <= rsel_n;
        ent_tag    <= tag_n;
        ent_next   <= next_n;
        ent_rstvec <= rstvec_n;
      end
    end
  end

  assign ent_rsel = rsel_q;
  assign cur_lvl  = cur;

  assert_entry_pending_R8: assert property (@(posedge clk) disable iff (!rstn_i)
    ent_stb |-> ipend_q[ent_lvl]);
  assert_entry_gdis_R8: assert property (@(posedge clk) disable iff (!rstn_i)
    (ent_stb && ent_lvl >= LV_HWERR) |-> ipend_q[LV_GDIS]);
  assert_dbl_no_entry_R10: assert property (@(posedge clk) disable iff (!rstn_i)
    dbl_flt |-> !ent_stb);
  assert_bg_gdis_R11: assert property (@(posedge clk) disable iff (!rstn_i)
    (acc_vld && !raise_vld) |-> !ipend_q[LV_GDIS]);
  assert_rstvec_range_R14: assert property (@(posedge clk) disable iff (!rstn_i)
    (ent_stb && ent_rstvec) |-> (ent_lvl >= 4'd7));
endmodule

// File: tb/nest_evt_ctrl_tb.sv
`timescale 1ns/1ps
module nest_evt_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] lat_req;
  logic raise_vld;
  logic [3:0] raise_lvl;
  logic [5:0] exc_cause;
  logic nest_en, ret_vld, ret_nested;
  logic [3:0] ret_lvl;
  logic ent_stb, ent_tag, ent_next, ent_rstvec, dbl_flt;
  logic [3:0] ent_lvl;
  logic [1:0] ent_rsel;
  logic [4:0] cur_lvl;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] AMASK = 3'd0, ALAT = 3'd1, APEND = 3'd2, APRIO = 3'd3, AOVR = 3'd4;

  always #2 clk = ~clk;

  nest_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lat_req(lat_req), .raise_vld(raise_vld), .raise_lvl(raise_lvl),
    .exc_cause(exc_cause), .nest_en(nest_en), .ret_vld(ret_vld), .ret_lvl(ret_lvl),
    .ret_nested(ret_nested), .ent_stb(ent_stb), .ent_lvl(ent_lvl), .ent_rsel(ent_rsel),
    .ent_tag(ent_tag), .ent_next(ent_next), .ent_rstvec(ent_rstvec), .dbl_flt(dbl_flt),
    .cur_lvl(cur_lvl)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    cmp(req, $sformatf("reg %0d", a), reg_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic raise_ev(input logic [3:0] l, input logic [5:0] c);
    raise_vld = 1'b1; raise_lvl = l; exc_cause = c;
    step();
    raise_vld = 1'b0;
  endtask

  task automatic ret_ev(input logic [3:0] l, input logic nst);
    ret_vld = 1'b1; ret_lvl = l; ret_nested = nst;
    step();
    ret_vld = 1'b0; ret_nested = 1'b0;
  endtask

  task automatic t_reset();
    rd("R1", AMASK, 32'h001F);
    rd("R1", APEND, 32'h0012);
    rd("R1", ALAT, 32'h0);
    rd("R1", APRIO, 32'h0);
    rd("R1", AOVR, 32'h0);
    cmp("R1", "ent_stb", ent_stb, 0);
    cmp("R1", "dbl_flt", dbl_flt, 0);
    cmp("R1", "cur_lvl", cur_lvl, 1);
  endtask

  task automatic t_mask();
    wr(AMASK, 32'hFFFF_0000); rd("R2", AMASK, 32'h001F);
    wr(AMASK, 32'h0000_FFE0); rd("R2", AMASK, 32'hFFFF);
    wr(AMASK, 32'h0000_00A0); rd("R2", AMASK, 32'h00BF);
  endtask

  task automatic t_readonly();
    wr(APEND, 32'h0); rd("R3", APEND, 32'h0012);
    wr(APEND, 32'hFFFF); rd("R3", APEND, 32'h0012);
    wr(APRIO, 32'hFFFF_FFFF); rd("R4", APRIO, 32'h001F);
  endtask

  task automatic t_latch();
    lat_req = 16'hFFFF; step(); lat_req = '0;
    rd("R4", ALAT, 32'hFFEF);
    wr(ALAT, 32'h0000_00F0); rd("R4", ALAT, 32'hFF0F);
    wr(ALAT, 32'h0000_FFFF); rd("R4", ALAT, 32'h0001);
    cmp("R4", "ent_stb", ent_stb, 0);
  endtask

  task automatic t_emu();
    raise_ev(4'd0, 6'd0);
    cmp("R5", "ent_stb", ent_stb, 1);
    cmp("R5", "ent_lvl", ent_lvl, 0);
    cmp("R8", "ent_rsel emu", ent_rsel, 0);
    rd("R8", APEND, 32'h0013);
    rd("R8", ALAT, 32'h0);
    step();
    cmp("R8", "strobe single cycle", ent_stb, 0);
    ret_ev(4'd0, 1'b0);
    rd("R12", APEND, 32'h0012);
  endtask

  task automatic t_gdis();
    wr(AMASK, 32'hFFFF);
    raise_ev(4'd9, 6'd0);
    cmp("R6", "ent_stb", ent_stb, 0);
    rd("R6", ALAT, 32'h0200);
    cmp("R6", "cur_lvl", cur_lvl, 1);
  endtask

  task automatic t_background();
    ret_ev(4'd1, 1'b0);
    cmp("R12", "cur_lvl user", cur_lvl, 16);
    cmp("R11", "no early entry", ent_stb, 0);
    rd("R12", APEND, 32'h0000);
    step();
    cmp("R11", "ent_stb", ent_stb, 1);
    cmp("R11", "ent_lvl", ent_lvl, 9);
    cmp("R8", "ent_rsel int", ent_rsel, 3);
    cmp("R9", "ent_tag", ent_tag, 0);
    rd("R8", APEND, 32'h0210);
    rd("R8", ALAT, 32'h0);
    cmp("R12", "cur_lvl", cur_lvl, 9);
  endtask

  task automatic t_masked();
    ret_ev(4'd9, 1'b0);
    rd("R12", APEND, 32'h0000);
    wr(AMASK, 32'h0);
    raise_ev(4'd8, 6'd0);
    cmp("R7", "ent_stb", ent_stb, 0);
    rd("R7", ALAT, 32'h0100);
    step();
    cmp("R7", "ent_stb later", ent_stb, 0);
    wr(AMASK, 32'hFFFF);
    cmp("R7", "ent_stb at write", ent_stb, 0);
    step();
    cmp("R7", "ent_stb after unmask", ent_stb, 1);
    cmp("R7", "ent_lvl", ent_lvl, 8);
    rd("R7", APEND, 32'h0110);
  endtask

  task automatic t_nest();
    ret_ev(4'd8, 1'b1);
    rd("R12", APEND, 32'h0100);
    raise_ev(4'd12, 6'd0);
    cmp("R9", "lower priority ent", ent_stb, 0);
    raise_ev(4'd8, 6'd0);
    cmp("R9", "equal no nest ent", ent_stb, 0);
    step();
    cmp("R9", "equal no nest bg", ent_stb, 0);
    rd("R9", ALAT, 32'h1100);
    nest_en = 1'b1;
    wr(AMASK, 32'hFFFF);
    step();
    cmp("R9", "nest ent_stb", ent_stb, 1);
    cmp("R9", "nest ent_lvl", ent_lvl, 8);
    cmp("R9", "nest ent_tag", ent_tag, 1);
    rd("R9", APEND, 32'h0110);
    rd("R9", ALAT, 32'h1000);
    nest_en = 1'b0;
  endtask

  task automatic t_fault();
    raise_ev(4'd2, 6'd0);
    cmp("R8", "nmi ent_stb", ent_stb, 1);
    cmp("R8", "nmi rsel", ent_rsel, 1);
    rd("R8", APEND, 32'h0114);
    raise_ev(4'd3, 6'h21);
    cmp("R10", "dbl_flt", dbl_flt, 1);
    cmp("R10", "no entry", ent_stb, 0);
    rd("R10", ALAT, 32'h1008);
    step();
    cmp("R10", "dbl pulse", dbl_flt, 0);
    ret_ev(4'd2, 1'b0);
    cmp("R12", "cur after nmi", cur_lvl, 8);
    step();
    raise_ev(4'd3, 6'h21);
    cmp("R13", "exc ent_stb", ent_stb, 1);
    cmp("R13", "exc rsel", ent_rsel, 2);
    cmp("R13", "exc next err", ent_next, 0);
    rd("R13", ALAT, 32'h1000);
    rd("R13", APEND, 32'h0118);
    ret_ev(4'd3, 1'b0);
    raise_ev(4'd3, 6'h05);
    cmp("R13", "exc ent_stb svc", ent_stb, 1);
    cmp("R13", "exc next svc", ent_next, 1);
    ret_ev(4'd3, 1'b0);
    rd("R12", APEND, 32'h0110);
  endtask

  task automatic t_override();
    wr(AOVR, 32'hFFFF);
    rd("R14", AOVR, 32'hFFFF);
    ret_ev(4'd8, 1'b0);
    rd("R12", APEND, 32'h0000);
    step();
    cmp("R14", "ent_stb", ent_stb, 1);
    cmp("R14", "ent_lvl", ent_lvl, 12);
    cmp("R14", "rstvec 12", ent_rstvec, 1);
    rd("R14", APEND, 32'h1010);
    ret_ev(4'd12, 1'b0);
    raise_ev(4'd6, 6'd0);
    cmp("R14", "ent_lvl 6", ent_lvl, 6);
    cmp("R14", "rstvec 6", ent_rstvec, 0);
    ret_ev(4'd6, 1'b0);
    rd("R12", APEND, 32'h0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; lat_req = '0;
    raise_vld = 1'b0; raise_lvl = '0; exc_cause = '0; nest_en = 1'b0;
    ret_vld = 1'b0; ret_lvl = '0; ret_nested = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_mask();
    t_readonly();
    t_latch();
    t_emu();
    t_gdis();
    t_background();
    t_masked();
    t_nest();
    t_fault();
    t_override();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule